// File: doc/BRIEF.md
# Address-Encoded NAND Command Sequencer

This block sits behind a 32-bit memory-mapped write port and turns every accepted write into raw cycles on an 8-bit parallel NAND bus. It has no control registers. The write address alone selects the kind of operation. A command write holds an opcode and an address-cycle count in its address bits, and it holds up to four address bytes in its data word. A data write pushes one 32-bit word onto the bus as four bytes. Flags in the address of a data write can mark the word as the last one for error-correction finalisation, and they can append a closing command cycle of the kind used to end a page program.

Every NAND cycle has a fixed strobe shape. The write port shows a ready signal that drops while a sequence runs. A write offered while the block is busy is held off and taken later, never lost. When more than four address cycles are needed, the block sends the first four, then waits with the chip still selected until a second write supplies the remaining bytes.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, and whenever reset is asserted mid-sequence, the block is idle: `nand_ce_n`=1, `nand_we_n`=1, `nand_cle`=0, `nand_ale`=0, `ecc_last`=0 and `wr_ready`=1.
- R2: A write whose address has bit 19 set and bit 24 clear is a command write. Its first bus cycle sends address bits 7:0 as an opcode, with `nand_cle`=1 and `nand_ale`=0.
- R3: A command write then issues N address cycles (`nand_ale`=1, `nand_cle`=0), where N is address bits 23:21 (0 to 7). The bytes come from the data word, bits 7:0 first. If N=0, only the opcode is sent.
- R4: When N>4, the block sends four address cycles and then waits with `nand_ce_n`=0, `nand_we_n`=1 and `wr_ready`=1. The next accepted write supplies the remaining N-4 bytes from its data word, bits 7:0 first. The address of that second write is not decoded.
- R5: A write whose address has bit 24 set and bit 19 clear is a data write. It sends its data word as four cycles, bits 7:0 first, with `nand_cle`=0 and `nand_ale`=0.
- R6: If address bit 20 is set in a data write, one opcode cycle carrying address bits 15:8 follows the last data byte. In a command write, bit 20 and bits 15:8 have no effect.
- R7: If address bit 17 is set in a data write, `ecc_last` is high for exactly one clock, in the clock that follows the end of the fourth data cycle. Otherwise `ecc_last` stays low.
- R8: In each bus cycle `nand_we_n` is low for 2 clocks, then high for 2 clocks. Consecutive cycles of one sequence follow with no further gap. `nand_cle` and `nand_ale` are never high together. `nand_ce_n` is low for the whole sequence.
- R9: `wr_ready` is low while a sequence runs. A write held on the port during that time is accepted once `wr_ready` returns and is carried out in full.
- R10: A write with both bit 19 and bit 24 set, or with neither set, is accepted and produces no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request on the memory-mapped port |
| wr_ready | output | 1 | Block can accept a write this clock |
| wr_addr | input | 25 | Write address, encodes the operation |
| wr_data | input | 32 | Write payload (address bytes or data) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe, active low, bus latches on its rising edge |
| nand_io | output | 8 | NAND data bus |
| ecc_last | output | 1 | One-clock pulse after the final byte of a flagged word |

## Verification
The bench targets three corner cases.

- Address counts of exactly four, five and seven. If the design miscounted the split, it would send a byte too many or too few, or it would never wait for the second write.
- The wait state before the second write. If the design released chip select there, or strobed stale data during it, the extra address bytes would end up on the wrong command.
- A write held on the port while the block is busy. If the design dropped that write or took it early, the data cycles would go missing or would corrupt the running sequence.

The flag combinations are checked too. A closing opcode must appear only in data writes, the ECC pulse must follow the fourth byte, and writes that select both phases or neither must leave the bus untouched.

// File: rtl/nand_aseq_pkg.sv
package nand_aseq_pkg;
  localparam int AW      = 25;
  localparam int DW      = 32;
  localparam int BYTES   = DW / 8;
  localparam int CNT_W   = 3;
  localparam int IW      = $clog2(BYTES + 1);
  localparam int B_DATA  = 24;
  localparam int B_CMD   = 19;
  localparam int B_OP2V  = 20;
  localparam int B_ECC   = 17;
  localparam int OP1_LSB = 0;
  localparam int OP2_LSB = 8;
  localparam int CNT_LSB = 21;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WAIT, S_DATA, S_CMD2
  } seq_state_e;

  typedef struct packed {
    logic             is_cmd;
    logic             is_data;
    logic [7:0]       op1;
    logic [7:0]       op2;
    logic             op2_en;
    logic             ecc;
    logic [CNT_W-1:0] naddr;
  } wr_dec_t;
endpackage

// File: rtl/nand_aseq_decode.sv
module nand_aseq_decode
  import nand_aseq_pkg::*;
(
  input  logic [AW-1:0] addr,
  output wr_dec_t       dec
);
  always_comb begin
    dec.is_cmd  = addr[B_CMD] & ~addr[B_DATA];
    dec.is_data = addr[B_DATA] & ~addr[B_CMD];
    dec.op1     = addr[OP1_LSB +: 8];
    dec.op2     = addr[OP2_LSB +: 8];
    dec.op2_en  = addr[B_OP2V];
    dec.ecc     = addr[B_ECC];
    dec.naddr   = addr[CNT_LSB +: CNT_W];
  end
endmodule

// File: rtl/nand_aseq_timer.sv
module nand_aseq_timer #(
  parameter int LO = 2,
  parameter int HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic we_low,
  output logic last
);
  localparam int P = LO + HI;
  localparam int W = (P > 1) ? $clog2(P) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    last   = run && (cnt_q == W'(P - 1));
    we_low = run && (cnt_q < W'(LO));
    if (!run)      cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_aseq_pkg::*;
#(
  parameter int WE_LO = 2,
  parameter int WE_HI = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic [7:0]    nand_io,
  output logic          ecc_last
);
  seq_state_e       state_q, state_d;
  logic [DW-1:0]    word_q, word_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [IW-1:0]    inword_q, inword_d;
  logic [7:0]       op1_q, op1_d, op2_q, op2_d;
  logic             op2en_q, op2en_d, ecc_q, ecc_d;
  logic             pulse_q, pulse_d;

  wr_dec_t dec;
  logic    run, we_low, last, accept;

  nand_aseq_decode u_dec (.addr(wr_addr), .dec(dec));

  nand_aseq_timer #(.LO(WE_LO), .HI(WE_HI)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .we_low(we_low), .last(last)
  );

  assign wr_ready = (state_q == S_IDLE) || (state_q == S_WAIT);
  assign accept   = wr_valid && wr_ready;
  assign run      = (state_q != S_IDLE) && (state_q != S_WAIT);

  always_comb begin
    state_d  = state_q;
    word_d   = word_q;
    left_d   = left_q;
    inword_d = inword_q;
    op1_d    = op1_q;
    op2_d    = op2_q;
    op2en_d  = op2en_q;
    ecc_d    = ecc_q;
    pulse_d  = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        if (dec.is_cmd) begin
          op1_d    = dec.op1;
          word_d   = wr_data;
          left_d   = dec.naddr;
          inword_d = IW'(BYTES);
          state_d  = S_CMD1;
        end else if (dec.is_data) begin
          word_d   = wr_data;
          inword_d = IW'(BYTES);
          op2_d    = dec.op2;
          op2en_d  = dec.op2_en;
          ecc_d    = dec.ecc;
          state_d  = S_DATA;
        end
      end
      S_CMD1: if (last) state_d = (left_q == '0) ? S_IDLE : S_ADDR;
      S_ADDR: if (last) begin
        word_d   = word_q >> 8;
        left_d   = left_q - CNT_W'(1);
        inword_d = inword_q - IW'(1);
        if (left_q == CNT_W'(1))      state_d = S_IDLE;
        else if (inword_q == IW'(1))  state_d = S_WAIT;
      end
      S_WAIT: if (accept) begin
        word_d   = wr_data;
        inword_d = IW'(BYTES);
        state_d  = S_ADDR;
      end
      S_DATA: if (last) begin
        word_d   = word_q >> 8;
        inword_d = inword_q - IW'(1);
        if (inword_q == IW'(1)) begin
          pulse_d = ecc_q;
          state_d = op2en_q ? S_CMD2 : S_IDLE;
        end
      end
      S_CMD2: if (last) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      word_q   <= '0;
      left_q   <= '0;
      inword_q <= '0;
      op1_q    <= '0;
      op2_q    <= '0;
      op2en_q  <= 1'b0;
      ecc_q    <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      word_q   <= word_d;
      left_q   <= left_d;
      inword_q <= inword_d;
      op1_q    <= op1_d;
      op2_q    <= op2_d;
      op2en_q  <= op2en_d;
      ecc_q    <= ecc_d;
      pulse_q  <= pulse_d;
    end
  end

  always_comb begin
    nand_ce_n = (state_q == S_IDLE);
    nand_cle  = (state_q == S_CMD1) || (state_q == S_CMD2);
    nand_ale  = (state_q == S_ADDR);
    nand_we_n = ~we_low;
    ecc_last  = pulse_q;
    unique case (state_q)
      S_CMD1:         nand_io = op1_q;
      S_CMD2:         nand_io = op2_q;
      S_ADDR, S_DATA: nand_io = word_q[7:0];
      default:        nand_io = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_aseq_chk.sv
module nand_aseq_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_ready,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic ecc_last
);
  a_r8_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r8_we_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |=> !nand_we_n);

  a_r8_we_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |=> nand_we_n);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && !nand_cle && !nand_ale));

  a_r7_ecc_single: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_last |=> !ecc_last);

  a_r9_busy_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !nand_ce_n);

  a_r4_wait_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !nand_ce_n) |-> (nand_we_n && !nand_cle && !nand_ale));
endmodule

bind nand_addr_seq nand_aseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .ecc_last(ecc_last)
);

// File: tb/nand_addr_seq_tb.sv
module nand_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [24:0] wr_addr;
  logic [31:0] wr_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, ecc_last;
  logic [7:0]  nand_io;

  always #5 clk = ~clk;

  nand_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_io(nand_io), .ecc_last(ecc_last)
  );

  // fields: {address[24:0], first payload, second payload}
  localparam int NV = 12;
  localparam logic [88:0] VEC [NV] = '{
    {25'h0080070, 32'h00000000, 32'h00000000},
    {25'h0680080, 32'h00A1B2C3, 32'h00000000},
    {25'h0A80000, 32'h44332211, 32'h00000055},
    {25'h0E80060, 32'hDDCCBBAA, 32'h00332211},
    {25'h0880090, 32'h04030201, 32'h00000000},
    {25'h1000000, 32'hCAFEF00D, 32'h00000000},
    {25'h1101000, 32'h12345678, 32'h00000000},
    {25'h1121000, 32'h89ABCDEF, 32'h00000000},
    {25'h0383090, 32'h000000EE, 32'h00000000},
    {25'h0000055, 32'h11111111, 32'h00000000},
    {25'h1080070, 32'h22222222, 32'h00000000},
    {25'h1020000, 32'h0F0E0D0C, 32'h00000000}
  };

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] obs_b [1024];
  int         obs_k [1024];
  logic [7:0] exp_b [1024];
  int         exp_k [1024];
  int n_obs = 0, n_exp = 0, n_ecc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor: kind 1 = opcode, 2 = address, 3 = data, 0 = both latches
  bit prev_we = 1'b1, gap_ok = 1'b0;
  int lowcnt = 0, highcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_we = 1'b1; gap_ok = 1'b0; lowcnt = 0; highcnt = 0;
    end else begin
      if (ecc_last) begin
        n_ecc++;
        chk(n_obs > 0 && obs_k[n_obs-1] == 3, "R7", "pulse follows data byte",
            n_obs > 0 ? obs_k[n_obs-1] : 0, 3);
      end
      if (wr_ready) gap_ok = 1'b0;
      if (!nand_we_n) begin
        if (prev_we && gap_ok)
          chk(highcnt == 2, "R8", "WE# high clocks", highcnt, 2);
        lowcnt++;
      end else if (!prev_we) begin
        chk(lowcnt == 2, "R8", "WE# low clocks", lowcnt, 2);
        obs_b[n_obs] = nand_io;
        obs_k[n_obs] = (nand_cle && nand_ale) ? 0 : nand_cle ? 1 : nand_ale ? 2 : 3;
        n_obs++;
        gap_ok = 1'b1; highcnt = 1; lowcnt = 0;
      end else begin
        highcnt++;
      end
      prev_we = nand_we_n;
    end
  end

  task automatic push_exp(input int k, input logic [7:0] b);
    exp_k[n_exp] = k; exp_b[n_exp] = b; n_exp++;
  endtask

  function automatic bit is_cmd(input logic [24:0] a);
    return a[19] && !a[24];
  endfunction
  function automatic bit is_dat(input logic [24:0] a);
    return a[24] && !a[19];
  endfunction

  task automatic build_exp(input logic [24:0] a, input logic [31:0] d1, input logic [31:0] d2);
    if (is_cmd(a)) begin
      push_exp(1, a[7:0]);
      for (int i = 0; i < int'(a[23:21]); i++)
        push_exp(2, (i < 4) ? d1[8*i +: 8] : d2[8*(i-4) +: 8]);
    end else if (is_dat(a)) begin
      for (int i = 0; i < 4; i++) push_exp(3, d1[8*i +: 8]);
      if (a[20]) push_exp(1, a[15:8]);
    end
  endtask

  task automatic send(input logic [24:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(nand_ce_n && wr_ready)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input int o0, input int e0, input string req);
    chk((n_obs - o0) == (n_exp - e0), req, "bus cycle count", n_obs - o0, n_exp - e0);
    for (int i = 0; i < n_exp - e0 && i < n_obs - o0; i++) begin
      chk(obs_k[o0+i] == exp_k[e0+i], req, "cycle kind", obs_k[o0+i], exp_k[e0+i]);
      chk(obs_b[o0+i] == exp_b[e0+i], req, "cycle byte", obs_b[o0+i], exp_b[e0+i]);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [24:0] a;
    logic [31:0] d1, d2;
    int o0, e0, c0;
    string tag;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !ecc_last && wr_ready,
        "R1", "idle after reset",
        {26'h0, nand_ce_n, nand_we_n, nand_cle, nand_ale, ecc_last, wr_ready}, 32'h31);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector walk: R2 R3 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      a = VEC[v][88:64]; d1 = VEC[v][63:32]; d2 = VEC[v][31:0];
      o0 = n_obs; e0 = n_exp; c0 = n_ecc;
      tag = is_cmd(a) ? "R2/R3" : is_dat(a) ? (a[20] ? "R5/R6" : "R5") : "R10";
      build_exp(a, d1, d2);
      send(a, d1);
      if (is_cmd(a) && a[23:21] > 3'd4) send(a, d2);
      wait_idle();
      compare(o0, e0, tag);
      chk((n_ecc - c0) == ((is_dat(a) && a[17]) ? 1 : 0), "R7", "ecc pulse clocks",
          n_ecc - c0, (is_dat(a) && a[17]) ? 1 : 0);
    end

    // R4 wait state between the two halves of a long address
    o0 = n_obs; e0 = n_exp;
    build_exp(25'h0A80000, 32'h44332211, 32'h000000AB);
    send(25'h0A80000, 32'h44332211);
    while (!wr_ready) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!nand_ce_n && nand_we_n && wr_ready, "R4", "wait state pins",
        {29'h0, nand_ce_n, nand_we_n, wr_ready}, 32'h3);
    chk((n_obs - o0) == 5, "R4", "cycles before second write", n_obs - o0, 5);
    send(25'h0000000, 32'h000000AB);
    wait_idle();
    compare(o0, e0, "R4");

    // R9 write held while busy
    o0 = n_obs; e0 = n_exp;
    build_exp(25'h0680080, 32'h00A1B2C3, 32'h0);
    build_exp(25'h1000000, 32'h11223344, 32'h0);
    send(25'h0680080, 32'h00A1B2C3);
    chk(!wr_ready, "R9", "ready while busy", wr_ready, 0);
    send(25'h1000000, 32'h11223344);
    wait_idle();
    compare(o0, e0, "R9");

    // R1 reset in the middle of a sequence
    send(25'h1101000, 32'h55667788);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !ecc_last && wr_ready,
        "R1", "idle after mid-sequence reset",
        {26'h0, nand_ce_n, nand_we_n, nand_cle, nand_ale, ecc_last, wr_ready}, 32'h31);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n, "R1", "stays idle after release",
        {30'h0, nand_ce_n, nand_we_n}, 32'h3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule